// File: doc/BRIEF.md
# UART Event Status Flags

This block sits next to an asynchronous serial receiver and transmitter and keeps two sticky event flags for software. On every received frame it checks the parity bit and the stop bit, forwards the byte into the receive FIFO with its own per-byte framing and parity indications, and raises a receive-error flag when either check fails. A faulty byte is still forwarded, and the receiver keeps going with the next frame. On the transmit side it counts bytes leaving the shifter and raises a transmit-stop flag when the count reaches a value that software has programmed.

Software reaches the block through a small register port. The status register holds both flags. A flag only clears when software writes 0 to it after an earlier read that saw it as 1. Each flag is a three-state machine:

- `FLG_CLEAR`: the flag reads 0.
- `FLG_UNREAD`: the flag reads 1 and no read has seen it yet.
- `FLG_ARMED`: the flag reads 1 and a read has seen it.

The transitions are:

- `set`: any state goes to `FLG_UNREAD` when an event arrives.
- `seen`: `FLG_UNREAD` goes to `FLG_ARMED` on a status read.
- `drop`: `FLG_ARMED` goes to `FLG_CLEAR` on a write of 0 to that bit, unless an event arrives in the same cycle.
- `reset`: any state goes to `FLG_CLEAR` on power-on reset or manual reset.

The address map is as follows.

- Address 0 is status: bit 1 is the receive error and bit 0 is the transmit stop.
- Address 1 is the transmit byte target.
- Address 2 is control: bit 0 selects odd parity (0 is even), bit 1 selects two stop bits, and bit 2 enables the receiver.
- Address 3 reads 0.

Top module: `uart_evt_status`

## Requirements
- R1: The transmit-stop flag (status bit 0) becomes 1 in the cycle after the tx_sent strobe that brings the byte count equal to the target register (address 1). Strobes before that leave it 0.
- R2: A frame whose checked stop bit is 0 sets the receive-error flag (status bit 1). In one-stop mode the checked bit is rx_stop[1].
- R3: A frame whose data bits and parity bit hold a count of ones that is odd in even mode (control bit 0 = 0), or even in odd mode (control bit 0 = 1), sets the receive-error flag.
- R4: In two-stop mode (control bit 1 = 1), only the first stop bit, rx_stop[0], is checked. rx_stop[1] is ignored.
- R5: A write of 0 to a flag bit at address 0 clears it only if an earlier status read returned 1 for that bit. Without such a read the flag stays 1.
- R6: Power-on reset (rst_n low) and manual reset (mrst high) both clear both flags to 0.
- R7: Every frame taken while the receiver is enabled is pushed to the FIFO one cycle after rx_done, with fifo_fer and fifo_per showing its own faults, whether or not it is faulty.
- R8: While the receiver is disabled (control bit 2 = 0), frames are not pushed or checked, and the receive-error flag keeps its value.
- R9: The byte counter restarts from 0 when the transmit-stop flag is cleared or when the target register is written.
- R10: A target of 0 never raises the transmit-stop flag.
- R11: A new event on a flag that was already read as 1 cancels that read, so a following write of 0 leaves the flag set.
- R12: An event in the same cycle as a valid clearing write leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| mrst | input | 1 | Synchronous manual reset, active high |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data, combinational from reg_addr |
| rx_done | input | 1 | Frame complete strobe from the receiver |
| rx_data | input | DATA_W | Received data bits |
| rx_par | input | 1 | Received parity bit |
| rx_stop | input | 2 | Sampled stop bits: [0] is the first, [1] is the last |
| tx_sent | input | 1 | Byte sent strobe from the transmitter |
| fifo_push | output | 1 | Receive FIFO write strobe |
| fifo_data | output | DATA_W | Byte pushed to the FIFO |
| fifo_fer | output | 1 | Framing fault of the pushed byte |
| fifo_per | output | 1 | Parity fault of the pushed byte |

## Verification
Frames are sent with clean data, with a wrong parity bit in each parity mode, and with stop-bit pairs that are good in one stop mode and bad in the other. This separates the parity check from the stop check, and separates which stop bit each mode samples. The clearing sequence is tried in four forms: a write with no read, a read followed by a write, a read followed by a new event and then a write, and a write in the same cycle as an event. These four forms separate the clearing rule from the set-priority rule. Transmit strobes are sent with targets of 3 and 0, and with a target rewrite part-way through a count, to show where the counter restarts.

// File: rtl/uest_pkg.sv
package uest_pkg;
    typedef enum logic [1:0] {
        FLG_CLEAR  = 2'd0,
        FLG_UNREAD = 2'd1,
        FLG_ARMED  = 2'd2
    } flag_st_t;

    localparam logic [1:0] ADDR_STAT = 2'd0;
    localparam logic [1:0] ADDR_TGT  = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

    localparam int BIT_TXSTOP = 0;
    localparam int BIT_RXERR  = 1;
endpackage

// File: rtl/uest_flag_fsm.sv
module uest_flag_fsm
    import uest_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mrst,
    input  logic set_evt,
    input  logic rd_hit,
    input  logic clr_wr,
    output logic flag,
    output logic clr_fire
);
    flag_st_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FLG_CLEAR;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (mrst) begin
            st_d = FLG_CLEAR;
        end else if (set_evt) begin
            st_d = FLG_UNREAD;
        end else begin
            unique case (st_q)
                FLG_CLEAR:  st_d = FLG_CLEAR;
                FLG_UNREAD: if (rd_hit) st_d = FLG_ARMED;
                FLG_ARMED:  if (clr_wr) st_d = FLG_CLEAR;
                default:    st_d = FLG_CLEAR;
            endcase
        end
    end

    always_comb begin
        flag     = (st_q != FLG_CLEAR);
        clr_fire = !mrst && !set_evt && (st_q == FLG_ARMED) && clr_wr;
    end
endmodule

// File: rtl/uest_tx_count.sv
module uest_tx_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tx_sent,
    input  logic             halt,
    input  logic [CNT_W-1:0] target,
    output logic             hit
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             step;

    always_comb begin
        cnt_inc = cnt_q + ONE;
        step    = tx_sent && !halt && !restart;
        hit     = step && (target != '0) && (cnt_inc == target);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (restart) cnt_q <= '0;
        else if (step)    cnt_q <= cnt_inc;
    end
endmodule

// File: rtl/uest_rx_check.sv
module uest_rx_check #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrst,
    input  logic              rx_en,
    input  logic              odd_par,
    input  logic              two_stop,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_par,
    input  logic [1:0]        rx_stop,
    output logic              err_evt,
    output logic              fifo_push,
    output logic [DATA_W-1:0] fifo_data,
    output logic              fifo_fer,
    output logic              fifo_per
);
    logic take, fer, per, stop_bit;

    always_comb begin
        take     = rx_done && rx_en && !mrst;
        stop_bit = two_stop ? rx_stop[0] : rx_stop[1];
        fer      = !stop_bit;
        per      = ((^rx_data) ^ rx_par) != odd_par;
        err_evt  = take && (fer || per);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_push <= 1'b0;
            fifo_data <= '0;
            fifo_fer  <= 1'b0;
            fifo_per  <= 1'b0;
        end else begin
            fifo_push <= take;
            if (take) begin
                fifo_data <= rx_data;
                fifo_fer  <= fer;
                fifo_per  <= per;
            end
        end
    end
endmodule

// File: rtl/uart_evt_status.sv
module uart_evt_status
    import uest_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrst,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_par,
    input  logic [1:0]        rx_stop,
    input  logic              tx_sent,
    output logic              fifo_push,
    output logic [DATA_W-1:0] fifo_data,
    output logic              fifo_fer,
    output logic              fifo_per
);
    localparam int NFLAG = 2;

    logic [2:0]       ctrl_q;
    logic [CNT_W-1:0] target_q;
    logic             stat_rd, stat_wr, tgt_wr, ctrl_wr;
    logic [NFLAG-1:0] evt, flags, clr_fire;
    logic             rx_err_evt, tx_hit, tx_restart;

    always_comb begin
        stat_rd = reg_rd && (reg_addr == ADDR_STAT);
        stat_wr = reg_wr && (reg_addr == ADDR_STAT);
        tgt_wr  = reg_wr && (reg_addr == ADDR_TGT);
        ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            target_q <= '0;
        end else if (mrst) begin
            ctrl_q   <= '0;
            target_q <= '0;
        end else begin
            if (ctrl_wr) ctrl_q   <= reg_wdata[2:0];
            if (tgt_wr)  target_q <= reg_wdata;
        end
    end

    uest_rx_check #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .mrst(mrst),
        .rx_en(ctrl_q[2]), .odd_par(ctrl_q[0]), .two_stop(ctrl_q[1]),
        .rx_done(rx_done), .rx_data(rx_data), .rx_par(rx_par), .rx_stop(rx_stop),
        .err_evt(rx_err_evt), .fifo_push(fifo_push), .fifo_data(fifo_data),
        .fifo_fer(fifo_fer), .fifo_per(fifo_per)
    );

    assign tx_restart = mrst || tgt_wr || clr_fire[BIT_TXSTOP];

    uest_tx_count #(.CNT_W(CNT_W)) u_txc (
        .clk(clk), .rst_n(rst_n), .restart(tx_restart), .tx_sent(tx_sent),
        .halt(flags[BIT_TXSTOP]), .target(target_q), .hit(tx_hit)
    );

    always_comb begin
        evt              = '0;
        evt[BIT_TXSTOP]  = tx_hit;
        evt[BIT_RXERR]   = rx_err_evt;
    end

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        uest_flag_fsm u_fsm (
            .clk(clk), .rst_n(rst_n), .mrst(mrst),
            .set_evt(evt[g]), .rd_hit(stat_rd),
            .clr_wr(stat_wr && !reg_wdata[g]),
            .flag(flags[g]), .clr_fire(clr_fire[g])
        );
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_STAT: reg_rdata[NFLAG-1:0] = flags;
            ADDR_TGT:  reg_rdata = target_q;
            ADDR_CTRL: reg_rdata[2:0] = ctrl_q;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/uest_chk.sv
module uest_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mrst,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [CNT_W-1:0] reg_wdata,
    input logic             rx_done,
    input logic             rx_en,
    input logic             tx_sent,
    input logic             rx_err_evt,
    input logic [1:0]       flags,
    input logic [CNT_W-1:0] target_q,
    input logic             fifo_push
);
    assert_push_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_en && !mrst) |=> fifo_push);

    assert_no_push_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_done || !rx_en) |=> !fifo_push);

    assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_err_evt && !mrst) |=> flags[1]);

    assert_fall_needs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[1]) |-> $past(mrst || (reg_wr && reg_addr == 2'd0 && !reg_wdata[1])));

    assert_mrst_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mrst |=> (flags == 2'b00));

    assert_tx_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[0]) |-> $past(tx_sent));

    assert_zero_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[0]) |-> ($past(target_q) != '0));
endmodule

bind uart_evt_status uest_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mrst(mrst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rx_done(rx_done), .rx_en(ctrl_q[2]), .tx_sent(tx_sent),
    .rx_err_evt(rx_err_evt), .flags(flags), .target_q(target_q), .fifo_push(fifo_push)
);

// File: tb/uart_evt_status_tb.sv
module uart_evt_status_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mrst = 1'b0;
    logic       reg_rd = 1'b0, reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       rx_done = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_par = 1'b0;
    logic [1:0] rx_stop = 2'b11;
    logic       tx_sent = 1'b0;
    logic       fifo_push, fifo_fer, fifo_per;
    logic [7:0] fifo_data;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    uart_evt_status u_dut (
        .clk(clk), .rst_n(rst_n), .mrst(mrst), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_done(rx_done), .rx_data(rx_data), .rx_par(rx_par), .rx_stop(rx_stop),
        .tx_sent(tx_sent), .fifo_push(fifo_push), .fifo_data(fifo_data),
        .fifo_fer(fifo_fer), .fifo_per(fifo_per)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic tx(input int n);
        for (int i = 0; i < n; i++) begin
            tx_sent = 1'b1;
            @(negedge clk);
            tx_sent = 1'b0;
        end
    endtask

    task automatic frame(input logic [7:0] d, input logic p, input logic [1:0] s);
        rx_done = 1'b1; rx_data = d; rx_par = p; rx_stop = s;
        @(negedge clk);
        rx_done = 1'b0;
    endtask

    task automatic status(output logic [7:0] v);
        reg_addr = 2'd0;
        #1 v = reg_rdata;
    endtask

    task automatic clear_all();
        logic [7:0] v;
        rd(2'd0, v);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        status(v);
        chk("R6 reset status", int'(v), 0);
        chk("R7 reset push", int'(fifo_push), 0);
    endtask

    task automatic t_tx_count();
        logic [7:0] v;
        wr(2'd1, 8'd3);
        tx(2); status(v);
        chk("R1 two of three", int'(v[0]), 0);
        tx(1); status(v);
        chk("R1 third byte", int'(v[0]), 1);
    endtask

    task automatic t_clear_rule();
        logic [7:0] v;
        wr(2'd0, 8'h00); status(v);
        chk("R5 write without read", int'(v[0]), 1);
        wr(2'd0, 8'h01); status(v);
        chk("R5 write one no effect", int'(v[0]), 1);
        rd(2'd0, v);
        chk("R5 read shows one", int'(v[0]), 1);
        wr(2'd0, 8'h00); status(v);
        chk("R5 read then write zero", int'(v[0]), 0);
        tx(2); status(v);
        chk("R9 restart after clear", int'(v[0]), 0);
        tx(1); status(v);
        chk("R9 match after clear", int'(v[0]), 1);
        clear_all();
    endtask

    task automatic t_target_rewrite();
        logic [7:0] v;
        tx(2);
        wr(2'd1, 8'd3);
        tx(2); status(v);
        chk("R9 rewrite restarts", int'(v[0]), 0);
        tx(1); status(v);
        chk("R9 match after rewrite", int'(v[0]), 1);
        clear_all();
        wr(2'd1, 8'd0);
        tx(4); status(v);
        chk("R10 zero target", int'(v[0]), 0);
        wr(2'd1, 8'd3);
    endtask

    task automatic t_parity();
        logic [7:0] v;
        frame(8'hA5, 1'b0, 2'b10);
        chk("R7 good push", int'(fifo_push), 1);
        chk("R7 good data", int'(fifo_data), 'hA5);
        chk("R3 good flags", int'({fifo_fer, fifo_per}), 0);
        status(v);
        chk("R3 no error even", int'(v[1]), 0);
        frame(8'h01, 1'b0, 2'b10);
        chk("R7 bad still pushed", int'(fifo_push), 1);
        chk("R7 bad data", int'(fifo_data), 'h01);
        chk("R3 per even", int'({fifo_fer, fifo_per}), 1);
        status(v);
        chk("R3 flag even", int'(v[1]), 1);
        clear_all();
        wr(2'd2, 8'h05);
        frame(8'h03, 1'b1, 2'b10); status(v);
        chk("R3 odd good", int'(v[1]), 0);
        frame(8'h03, 1'b0, 2'b10);
        chk("R3 per odd", int'(fifo_per), 1);
        status(v);
        chk("R3 flag odd", int'(v[1]), 1);
        clear_all();
        wr(2'd2, 8'h04);
    endtask

    task automatic t_stop();
        logic [7:0] v;
        frame(8'h00, 1'b0, 2'b01);
        chk("R2 fer one-stop", int'({fifo_fer, fifo_per}), 2);
        status(v);
        chk("R2 flag one-stop", int'(v[1]), 1);
        clear_all();
        wr(2'd2, 8'h06);
        frame(8'h00, 1'b0, 2'b01); status(v);
        chk("R4 second stop ignored", int'({v[1], fifo_fer}), 0);
        frame(8'h00, 1'b0, 2'b10);
        chk("R4 first stop checked", int'(fifo_fer), 1);
        clear_all();
        wr(2'd2, 8'h04);
    endtask

    task automatic t_marker();
        logic [7:0] v;
        frame(8'h01, 1'b0, 2'b10);
        rd(2'd0, v);
        frame(8'h01, 1'b0, 2'b10);
        wr(2'd0, 8'h00); status(v);
        chk("R11 new event drops read", int'(v[1]), 1);
        rd(2'd0, v);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h00;
        rx_done = 1'b1; rx_data = 8'h01; rx_par = 1'b0; rx_stop = 2'b10;
        @(negedge clk);
        reg_wr = 1'b0; rx_done = 1'b0;
        status(v);
        chk("R12 set beats clear", int'(v[1]), 1);
    endtask

    task automatic t_disable();
        logic [7:0] v;
        wr(2'd2, 8'h00); status(v);
        chk("R8 flag kept", int'(v[1]), 1);
        clear_all();
        frame(8'h01, 1'b0, 2'b00);
        chk("R8 no push", int'(fifo_push), 0);
        status(v);
        chk("R8 no check", int'(v[1]), 0);
        wr(2'd2, 8'h04);
    endtask

    task automatic t_mrst();
        logic [7:0] v;
        tx(3);
        frame(8'h01, 1'b0, 2'b10);
        status(v);
        chk("R6 both set", int'(v[1:0]), 3);
        mrst = 1'b1;
        @(negedge clk);
        mrst = 1'b0;
        status(v);
        chk("R6 manual reset", int'(v[1:0]), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        wr(2'd2, 8'h04);
        t_tx_count();
        t_clear_rule();
        t_target_rewrite();
        t_parity();
        t_stop();
        t_marker();
        t_disable();
        t_mrst();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule